// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative cache of page-table entries for an address translation unit. Every slot stores a physical page number, a virtual page tag, an address-space number and a global flag. It also stores two permission masks, one for reads and one for writes, with one bit per processor mode, and two trap bits: one that traps on read and one that traps on write. A combinational lookup port takes a virtual page number and the current address-space number. In the same cycle it returns hit, the slot index and the stored fields of the matching entry.

New entries go into the slot named by a round-robin replace pointer, whatever that slot held before. Three flush commands exist. One invalidates everything. One removes only the entries that are not global. One removes the entries that a given page and address-space pair would hit. An index port shows the slot under the replace pointer and can step the pointer on request, so surrounding logic can inspect or claim the next victim.

The block does not walk page tables, check permissions or report faults. It only stores entries and matches them.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits only on a valid slot whose tag equals `lk_vpn` and which is either global or holds an address-space number equal to `lk_asn`.
- R2: Lookup is combinational. On a hit, `lk_idx` and every `lk_*` field show the matching slot in the same cycle. On a miss, `lk_hit` is 0 and all `lk_*` field outputs are 0.
- R3: When several slots match, the one with the lowest index is reported.
- R4: An insert (`ins_valid`=1) writes the slot named by the replace pointer, overwriting any valid entry there. It stores `ins_vpn` as the tag and marks the slot valid.
- R5: The replace pointer advances by exactly one on each cycle with an insert or an index-port step (`ptr_rd`), and wraps from DEPTH-1 to 0. Otherwise it holds.
- R6: `flush_op`=1 (flush all) invalidates every slot and returns the replace pointer to 0.
- R7: `flush_op`=2 (flush local) invalidates every slot whose global bit is clear and leaves global slots valid.
- R8: `flush_op`=3 (flush page) invalidates every slot that a lookup with `flush_vpn`/`flush_asn` would hit, under the rule of R1. Other slots stay valid. `flush_op`=0 does nothing.
- R9: A flush and an insert in the same cycle act as flush first, then insert: the inserted entry survives. With flush all, the insert lands in slot 0 and the pointer becomes 1.
- R10: The index port shows, without delay, the valid bit, tag, physical page, address-space number and global bit of the slot under the replace pointer, together with the pointer itself (`rp_idx`).
- R11: After reset every slot is invalid and the replace pointer is 0.
- R12: The read mask, write mask, trap-on-read and trap-on-write bits are stored and returned independently of one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Index of the matching slot |
| lk_ppn | output | PPN_W | Physical page of the hit |
| lk_rd_en | output | MODES | Per-mode read enable of the hit |
| lk_wr_en | output | MODES | Per-mode write enable of the hit |
| lk_trap_rd | output | 1 | Trap-on-read bit of the hit |
| lk_trap_wr | output | 1 | Trap-on-write bit of the hit |
| lk_global | output | 1 | Global bit of the hit |
| ins_valid | input | 1 | Insert request |
| ins_vpn | input | VPN_W | Tag of the new entry |
| ins_asn | input | ASN_W | Address-space number of the new entry |
| ins_global | input | 1 | Global bit of the new entry |
| ins_ppn | input | PPN_W | Physical page of the new entry |
| ins_rd_en | input | MODES | Read mask of the new entry |
| ins_wr_en | input | MODES | Write mask of the new entry |
| ins_trap_rd | input | 1 | Trap-on-read bit of the new entry |
| ins_trap_wr | input | 1 | Trap-on-write bit of the new entry |
| flush_op | input | 2 | 0 none, 1 all, 2 local, 3 page |
| flush_vpn | input | VPN_W | Page for flush page |
| flush_asn | input | ASN_W | Address-space number for flush page |
| ptr_rd | input | 1 | Step the replace pointer |
| rp_idx | output | IDX_W | Current replace pointer |
| vic_valid | output | 1 | Valid bit of the slot at the pointer |
| vic_vpn | output | VPN_W | Tag of the slot at the pointer |
| vic_ppn | output | PPN_W | Physical page of the slot at the pointer |
| vic_asn | output | ASN_W | Address-space number of the slot at the pointer |
| vic_global | output | 1 | Global bit of the slot at the pointer |

## Verification
Lookups are tried against a fixed table that deliberately contains the same page under two address-space numbers and also as a global entry. Probes with matching numbers, mismatching numbers and unknown pages separate the number-match path from the global path, and they show that the lowest index wins. Each flush kind is followed by probes of both global and non-global pages, which shows which slots each command spares. Flushes that coincide with inserts, a pointer step through the index port and a wrap of the pointer confirm the ordering of flush and insert and the round-robin slot choice.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    FLUSH_NONE  = 2'd0,
    FLUSH_ALL   = 2'd1,
    FLUSH_LOCAL = 2'd2,
    FLUSH_PAGE  = 2'd3
  } flush_op_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int DEPTH = 64,
  parameter int VPN_W = 30,
  parameter int ASN_W = 8
) (
  input  logic [DEPTH-1:0] valid_vec,
  input  logic [DEPTH-1:0] glob_vec,
  input  logic [VPN_W-1:0] tag_arr [DEPTH],
  input  logic [ASN_W-1:0] asn_arr [DEPTH],
  input  logic [VPN_W-1:0] key_vpn,
  input  logic [ASN_W-1:0] key_asn,
  output logic [DEPTH-1:0] match_vec
);
  function automatic logic slot_hits(input logic v, input logic g,
                                     input logic [VPN_W-1:0] tag, input logic [ASN_W-1:0] asn,
                                     input logic [VPN_W-1:0] kv, input logic [ASN_W-1:0] ka);
    return v && (tag == kv) && (g || (asn == ka));
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_vec[g] = slot_hits(valid_vec[g], glob_vec[g], tag_arr[g], asn_arr[g],
                                    key_vpn, key_asn);
  end
endmodule

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic [DEPTH-1:0] vec,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  output logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] slot
);
  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic [IDX_W-1:0] ptr_q;
  assign ptr  = ptr_q;
  assign slot = restart ? '0 : ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= '0;
    else if (step) ptr_q <= wrap_inc(slot);
    else           ptr_q <= slot;
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int VPN_W = 30,
  parameter int PPN_W = 28,
  parameter int ASN_W = 8,
  parameter int MODES = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [MODES-1:0] lk_rd_en,
  output logic [MODES-1:0] lk_wr_en,
  output logic             lk_trap_rd,
  output logic             lk_trap_wr,
  output logic             lk_global,
  input  logic             ins_valid,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [ASN_W-1:0] ins_asn,
  input  logic             ins_global,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [MODES-1:0] ins_rd_en,
  input  logic [MODES-1:0] ins_wr_en,
  input  logic             ins_trap_rd,
  input  logic             ins_trap_wr,
  input  logic [1:0]       flush_op,
  input  logic [VPN_W-1:0] flush_vpn,
  input  logic [ASN_W-1:0] flush_asn,
  input  logic             ptr_rd,
  output logic [IDX_W-1:0] rp_idx,
  output logic             vic_valid,
  output logic [VPN_W-1:0] vic_vpn,
  output logic [PPN_W-1:0] vic_ppn,
  output logic [ASN_W-1:0] vic_asn,
  output logic             vic_global
);
  // Slot storage
  logic             vld_q [DEPTH];
  logic             glb_q [DEPTH];
  logic             trd_q [DEPTH];
  logic             twr_q [DEPTH];
  logic [VPN_W-1:0] tag_q [DEPTH];
  logic [ASN_W-1:0] asn_q [DEPTH];
  logic [PPN_W-1:0] ppn_q [DEPTH];
  logic [MODES-1:0] rde_q [DEPTH];
  logic [MODES-1:0] wre_q [DEPTH];

  // Named internal events, visible to the checker
  flush_op_e        op;
  logic             do_all, do_local, do_page;
  logic [DEPTH-1:0] valid_vec, glob_vec, hit_vec, page_vec, kill_vec;
  logic [IDX_W-1:0] ins_slot;

  assign op       = flush_op_e'(flush_op);
  assign do_all   = (op == FLUSH_ALL);
  assign do_local = (op == FLUSH_LOCAL);
  assign do_page  = (op == FLUSH_PAGE);

  for (genvar g = 0; g < DEPTH; g++) begin : g_vec
    assign valid_vec[g] = vld_q[g];
    assign glob_vec[g]  = glb_q[g];
    assign kill_vec[g]  = do_all | (do_local & ~glb_q[g]) | (do_page & page_vec[g]);
  end

  tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
    .valid_vec(valid_vec), .glob_vec(glob_vec), .tag_arr(tag_q), .asn_arr(asn_q),
    .key_vpn(lk_vpn), .key_asn(lk_asn), .match_vec(hit_vec)
  );

  tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
    .valid_vec(valid_vec), .glob_vec(glob_vec), .tag_arr(tag_q), .asn_arr(asn_q),
    .key_vpn(flush_vpn), .key_asn(flush_asn), .match_vec(page_vec)
  );

  tlb_first_set #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .vec(hit_vec), .found(lk_hit), .idx(lk_idx)
  );

  tlb_rr_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .restart(do_all), .step(ins_valid | ptr_rd),
    .ptr(rp_idx), .slot(ins_slot)
  );

  // Per-slot update: flush clears first, an insert into the slot then wins
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        glb_q[g] <= 1'b0;
        trd_q[g] <= 1'b0;
        twr_q[g] <= 1'b0;
        tag_q[g] <= '0;
        asn_q[g] <= '0;
        ppn_q[g] <= '0;
        rde_q[g] <= '0;
        wre_q[g] <= '0;
      end else if (ins_valid && (ins_slot == IDX_W'(g))) begin
        vld_q[g] <= 1'b1;
        glb_q[g] <= ins_global;
        trd_q[g] <= ins_trap_rd;
        twr_q[g] <= ins_trap_wr;
        tag_q[g] <= ins_vpn;
        asn_q[g] <= ins_asn;
        ppn_q[g] <= ins_ppn;
        rde_q[g] <= ins_rd_en;
        wre_q[g] <= ins_wr_en;
      end else if (kill_vec[g]) begin
        vld_q[g] <= 1'b0;
      end
    end
  end

  // Lookup fields, zero on a miss
  assign lk_ppn     = lk_hit ? ppn_q[lk_idx] : '0;
  assign lk_rd_en   = lk_hit ? rde_q[lk_idx] : '0;
  assign lk_wr_en   = lk_hit ? wre_q[lk_idx] : '0;
  assign lk_trap_rd = lk_hit & trd_q[lk_idx];
  assign lk_trap_wr = lk_hit & twr_q[lk_idx];
  assign lk_global  = lk_hit & glb_q[lk_idx];

  // Index port
  assign vic_valid  = vld_q[rp_idx];
  assign vic_vpn    = tag_q[rp_idx];
  assign vic_ppn    = ppn_q[rp_idx];
  assign vic_asn    = asn_q[rp_idx];
  assign vic_global = glb_q[rp_idx];
endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ins_valid,
  input logic             ptr_rd,
  input logic [1:0]       flush_op,
  input logic             lk_hit,
  input logic [IDX_W-1:0] lk_idx,
  input logic [DEPTH-1:0] hit_vec,
  input logic [DEPTH-1:0] valid_vec,
  input logic [DEPTH-1:0] glob_vec,
  input logic [IDX_W-1:0] rp_idx,
  input logic [IDX_W-1:0] ins_slot
);
  a_r1_hit_slot_valid: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> valid_vec[lk_idx]);

  a_r2_miss_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (hit_vec == '0));

  a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> ((hit_vec & ~({DEPTH{1'b1}} << lk_idx)) == '0));

  a_r4_insert_valid: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> valid_vec[$past(ins_slot)]);

  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    ((ins_valid || ptr_rd) && flush_op != 2'd1) |=>
      rp_idx == (($past(rp_idx) == IDX_W'(DEPTH - 1)) ? '0 : $past(rp_idx) + 1'b1));

  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_valid && !ptr_rd && flush_op != 2'd1) |=> $stable(rp_idx));

  a_r6_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_op == 2'd1 && !ins_valid) |=> (valid_vec == '0 && rp_idx == '0));

  a_r7_local_gone: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_op == 2'd2 && !ins_valid) |=> ((valid_vec & ~$past(glob_vec)) == '0));

  a_r7_global_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_op == 2'd2) |=> ((valid_vec & $past(glob_vec)) == ($past(valid_vec) & $past(glob_vec))));

  a_r9_all_then_insert: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_op == 2'd1 && ins_valid) |=> (valid_vec == {{(DEPTH-1){1'b0}}, 1'b1} && rp_idx == IDX_W'(1)));
endmodule

bind asid_tlb tlb_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ptr_rd(ptr_rd), .flush_op(flush_op),
  .lk_hit(lk_hit), .lk_idx(lk_idx), .hit_vec(hit_vec), .valid_vec(valid_vec),
  .glob_vec(glob_vec), .rp_idx(rp_idx), .ins_slot(ins_slot)
);

// File: tb/asid_tlb_bench.sv
`timescale 1ns/1ps
module asid_tlb_bench;
  localparam int DEPTH = 8;
  localparam int VPN_W = 16;
  localparam int PPN_W = 12;
  localparam int ASN_W = 8;
  localparam int MODES = 4;
  localparam int IDX_W = 3;

  // {vpn[39:24], asn[23:16], hit[15], idx[14:12], ppn[11:0]}
  localparam logic [39:0] PROBES [8] = '{
    {16'h0010, 8'd1, 1'b1, 3'd0, 12'h100},  // R1 asn match, R3 beats global slot 4
    {16'h0010, 8'd2, 1'b1, 3'd1, 12'h101},  // R1 second asn
    {16'h0010, 8'd7, 1'b1, 3'd4, 12'h104},  // R1 global path
    {16'h0010, 8'd3, 1'b1, 3'd4, 12'h104},  // R1 global with equal asn
    {16'h0020, 8'd9, 1'b1, 3'd2, 12'h102},  // R1 global, foreign asn
    {16'h0030, 8'd2, 1'b0, 3'd0, 12'h000},  // R1 asn mismatch -> miss
    {16'h0030, 8'd1, 1'b1, 3'd3, 12'h103},  // R1 asn match
    {16'h0040, 8'd1, 1'b0, 3'd0, 12'h000}   // R1 unknown page
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [VPN_W-1:0] lk_vpn = '0, ins_vpn = '0, flush_vpn = '0, vic_vpn;
  logic [ASN_W-1:0] lk_asn = '0, ins_asn = '0, flush_asn = '0, vic_asn;
  logic [PPN_W-1:0] lk_ppn, ins_ppn = '0, vic_ppn;
  logic [MODES-1:0] lk_rd_en, lk_wr_en, ins_rd_en = '0, ins_wr_en = '0;
  logic lk_hit, lk_trap_rd, lk_trap_wr, lk_global, vic_valid, vic_global;
  logic ins_valid = 1'b0, ins_global = 1'b0, ins_trap_rd = 1'b0, ins_trap_wr = 1'b0, ptr_rd = 1'b0;
  logic [1:0] flush_op = 2'd0;
  logic [IDX_W-1:0] lk_idx, rp_idx;
  int n_chk = 0, n_err = 0;

  always #2.5 clk = ~clk;

  asid_tlb #(.DEPTH(DEPTH), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)) u_asid_tlb (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en), .lk_trap_rd(lk_trap_rd),
    .lk_trap_wr(lk_trap_wr), .lk_global(lk_global), .ins_valid(ins_valid), .ins_vpn(ins_vpn),
    .ins_asn(ins_asn), .ins_global(ins_global), .ins_ppn(ins_ppn), .ins_rd_en(ins_rd_en),
    .ins_wr_en(ins_wr_en), .ins_trap_rd(ins_trap_rd), .ins_trap_wr(ins_trap_wr),
    .flush_op(flush_op), .flush_vpn(flush_vpn), .flush_asn(flush_asn), .ptr_rd(ptr_rd),
    .rp_idx(rp_idx), .vic_valid(vic_valid), .vic_vpn(vic_vpn), .vic_ppn(vic_ppn),
    .vic_asn(vic_asn), .vic_global(vic_global)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic ins(input logic [15:0] v, input logic [7:0] a, input logic gl, input logic [11:0] p,
                     input logic [3:0] rd, input logic [3:0] wr, input logic tr, input logic tw);
    ins_vpn = v; ins_asn = a; ins_global = gl; ins_ppn = p;
    ins_rd_en = rd; ins_wr_en = wr; ins_trap_rd = tr; ins_trap_wr = tw;
    ins_valid = 1'b1;
    cyc();
    ins_valid = 1'b0;
  endtask

  task automatic flush(input logic [1:0] fop, input logic [15:0] v, input logic [7:0] a);
    flush_op = fop; flush_vpn = v; flush_asn = a;
    cyc();
    flush_op = 2'd0;
  endtask

  task automatic probe(input string tag, input logic [15:0] v, input logic [7:0] a,
                       input logic h, input logic [2:0] ix, input logic [11:0] p);
    lk_vpn = v; lk_asn = a; #1;
    chk({tag, " hit"}, 32'(lk_hit), 32'(h));
    if (h) begin
      chk({tag, " idx"}, 32'(lk_idx), 32'(ix));
      chk({tag, " ppn"}, 32'(lk_ppn), 32'(p));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R11 reset state
    chk("R11 ptr", 32'(rp_idx), 0);
    chk("R11 vic_valid", 32'(vic_valid), 0);
    probe("R11 empty", 16'h0010, 8'd1, 1'b0, 3'd0, 12'h0);

    ins(16'h0010, 8'd1, 1'b0, 12'h100, 4'b0101, 4'b0001, 1'b1, 1'b0);
    ins(16'h0010, 8'd2, 1'b0, 12'h101, 4'b1010, 4'b0110, 1'b0, 1'b1);
    ins(16'h0020, 8'd5, 1'b1, 12'h102, 4'b1111, 4'b1111, 1'b0, 1'b0);
    ins(16'h0030, 8'd1, 1'b0, 12'h103, 4'b0001, 4'b0000, 1'b0, 1'b0);
    ins(16'h0010, 8'd3, 1'b1, 12'h104, 4'b1000, 4'b1000, 1'b1, 1'b1);

    for (int i = 0; i < 8; i++) begin
      probe($sformatf("R1/R3 vec%0d", i), PROBES[i][39:24], PROBES[i][23:16],
            PROBES[i][15], PROBES[i][14:12], PROBES[i][11:0]);
    end

    // R12 independent permission and trap fields
    probe("R12 slot0", 16'h0010, 8'd1, 1'b1, 3'd0, 12'h100);
    chk("R12 rd0", 32'(lk_rd_en), 32'h5);
    chk("R12 wr0", 32'(lk_wr_en), 32'h1);
    chk("R12 trd0", 32'(lk_trap_rd), 1);
    chk("R12 twr0", 32'(lk_trap_wr), 0);
    probe("R12 slot1", 16'h0010, 8'd2, 1'b1, 3'd1, 12'h101);
    chk("R12 rd1", 32'(lk_rd_en), 32'hA);
    chk("R12 wr1", 32'(lk_wr_en), 32'h6);
    chk("R12 trd1", 32'(lk_trap_rd), 0);
    chk("R12 twr1", 32'(lk_trap_wr), 1);
    // R2 miss zeroes fields
    probe("R2 miss", 16'h0040, 8'd1, 1'b0, 3'd0, 12'h0);
    chk("R2 miss ppn", 32'(lk_ppn), 0);
    chk("R2 miss rd", 32'(lk_rd_en), 0);
    chk("R2 miss global", 32'(lk_global), 0);

    // R10 index port and pointer step
    chk("R10 ptr", 32'(rp_idx), 5);
    chk("R10 vic_valid", 32'(vic_valid), 0);
    ptr_rd = 1'b1; cyc(); ptr_rd = 1'b0;
    chk("R10 ptr step", 32'(rp_idx), 6);
    ins(16'h0060, 8'd1, 1'b0, 12'h106, 4'b0001, 4'b0001, 1'b0, 1'b0);
    ins(16'h0070, 8'd1, 1'b1, 12'h107, 4'b0001, 4'b0001, 1'b0, 1'b0);
    chk("R5 wrap", 32'(rp_idx), 0);
    chk("R10 vic_valid", 32'(vic_valid), 1);
    chk("R10 vic_vpn", 32'(vic_vpn), 32'h10);
    chk("R10 vic_asn", 32'(vic_asn), 1);

    // R4 overwrite slot 0
    ins(16'h0050, 8'd1, 1'b0, 12'h150, 4'b0001, 4'b0001, 1'b0, 1'b0);
    chk("R5 ptr after wrap", 32'(rp_idx), 1);
    probe("R4 old gone", 16'h0010, 8'd1, 1'b1, 3'd4, 12'h104);
    probe("R4 new", 16'h0050, 8'd1, 1'b1, 3'd0, 12'h150);

    // R8 flush page
    flush(2'd3, 16'h0010, 8'd2);
    probe("R8 asn slot", 16'h0010, 8'd2, 1'b0, 3'd0, 12'h0);
    probe("R8 global slot", 16'h0010, 8'd3, 1'b0, 3'd0, 12'h0);
    probe("R8 other kept", 16'h0030, 8'd1, 1'b1, 3'd3, 12'h103);
    probe("R8 other kept2", 16'h0050, 8'd1, 1'b1, 3'd0, 12'h150);
    flush(2'd0, 16'h0050, 8'd1);
    probe("R8 none op", 16'h0050, 8'd1, 1'b1, 3'd0, 12'h150);

    // R7 flush local
    flush(2'd2, 16'h0, 8'd0);
    probe("R7 local0", 16'h0050, 8'd1, 1'b0, 3'd0, 12'h0);
    probe("R7 local3", 16'h0030, 8'd1, 1'b0, 3'd0, 12'h0);
    probe("R7 local6", 16'h0060, 8'd1, 1'b0, 3'd0, 12'h0);
    probe("R7 global2", 16'h0020, 8'd9, 1'b1, 3'd2, 12'h102);
    probe("R7 global7", 16'h0070, 8'd3, 1'b1, 3'd7, 12'h107);
    chk("R7 ptr kept", 32'(rp_idx), 1);

    // R9 flush all with insert
    flush_op = 2'd1;
    ins(16'h0080, 8'd4, 1'b0, 12'h180, 4'b0001, 4'b0001, 1'b0, 1'b0);
    flush_op = 2'd0;
    probe("R9 all+ins", 16'h0080, 8'd4, 1'b1, 3'd0, 12'h180);
    probe("R9 all cleared", 16'h0020, 8'd9, 1'b0, 3'd0, 12'h0);
    chk("R9 ptr", 32'(rp_idx), 1);
    // R9 flush local with insert
    flush_op = 2'd2;
    ins(16'h0090, 8'd4, 1'b0, 12'h190, 4'b0001, 4'b0001, 1'b0, 1'b0);
    flush_op = 2'd0;
    probe("R9 local+ins", 16'h0090, 8'd4, 1'b1, 3'd1, 12'h190);
    probe("R9 local cleared", 16'h0080, 8'd4, 1'b0, 3'd0, 12'h0);
    // R9 flush page with insert of the same page
    flush_op = 2'd3; flush_vpn = 16'h0090; flush_asn = 8'd4;
    ins(16'h0090, 8'd4, 1'b0, 12'h191, 4'b0001, 4'b0001, 1'b0, 1'b0);
    flush_op = 2'd0;
    probe("R9 page+ins", 16'h0090, 8'd4, 1'b1, 3'd2, 12'h191);
    chk("R9 ptr3", 32'(rp_idx), 3);

    // R6 flush all alone
    flush(2'd1, 16'h0, 8'd0);
    chk("R6 ptr", 32'(rp_idx), 0);
    chk("R6 vic_valid", 32'(vic_valid), 0);
    probe("R6 cleared", 16'h0090, 8'd4, 1'b0, 3'd0, 12'h0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule